// File: doc/BRIEF.md
# TDM Control-Signal Multiplexer Master

This block sits on the base board and carries slow modem handshake lines across a single pair of serial wires. At the start of each frame it takes a snapshot of seven parallel control outputs. It then shifts the snapshot out, one bit per time slot, over a 16-slot frame on a serial output line. Over the same frame it collects a matching 16-slot frame from a serial input line and presents seven modem-status bits as registered parallel outputs.

The block generates the bit clock by dividing its system clock. It also drives an active-low frame strobe, which the far end uses to find slot boundaries. The strobe is placed in the last slot of the frame and not in the first. No software action is involved: a level applied to a control input appears at the far end after one frame of delay.

Top module: `tdm_ctl_mux`

## Requirements
- R1: The bit clock `bclk_o` has a period of 2*HALF_DIV system clocks. It is low for the first HALF_DIV clocks of every slot and high for the last HALF_DIV clocks.
- R2: A frame is 16 slots, numbered 0 to 15. `sync_n_o` is low for exactly one bit time, during slot 15, and high in every other slot. It rises at the same edge where `bclk_o` falls to start slot 0.
- R3: Slot k of `sdo_o` carries `tx_ctl_i[k]` for k = 0..6. The assignments are: 0 channel-3 request-to-send, 1 channel-3 terminal-ready, 2 channel-3 local loopback / mode select, 3 channel-3 remote loopback, 4 channel-4 request-to-send, 5 channel-4 terminal-ready, 6 channel-4 local loopback. Slots 7 to 15 carry 0.
- R4: `tx_ctl_i` is captured at the system-clock edge that begins slot 0. A change made as late as one system clock before that edge is carried in the new frame. A change made after that edge has no effect on the frame in progress.
- R5: `sdo_o` changes only at a system-clock edge where `bclk_o` falls.
- R6: `sdi_i` is sampled at the edge where `bclk_o` rises. The bit of slot k goes to `rx_sts_o[k]` for k = 0..6. The assignments are: 0 channel-3 clear-to-send, 1 channel-3 set-ready / ID bit 1, 2 channel-3 carrier detect, 3 channel-3 test mode / ID bit 0, 4 channel-3 ring, 5 channel-4 clear-to-send, 6 channel-4 set-ready / ID bit 3. Bits received in slots 7 to 15 have no effect.
- R7: All bits of `rx_sts_o` update together, at the edge that ends slot 15, to the frame just received. They hold their value at every other edge.
- R8: During reset `bclk_o` is low, `sync_n_o` is high, `sdo_o` is 0 and `rx_sts_o` is all zero. Slot 0 starts when reset is released, and the first frame after reset sends all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 2*HALF_DIV times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ctl_i | input | TX_USED | Parallel modem-control levels to send |
| sdi_i | input | 1 | Serial frame from the far end |
| bclk_o | output | 1 | Bit clock for both serial lines |
| sync_n_o | output | 1 | Active-low frame strobe, low in slot 15 |
| sdo_o | output | 1 | Serial frame to the far end |
| rx_sts_o | output | RX_USED | Registered modem-status levels received |

## Verification
One edge ends slot 15 and does several things at once. It loads the new control snapshot, launches the slot-0 bit, releases the frame strobe and updates the status outputs. The bench targets this edge in alternate frames: it changes `tx_ctl_i` one system clock before the edge, and the far-end frame content changes at the same frame boundary. A scoreboard then compares each outgoing frame with the late value. The status outputs are checked just after that edge against the frame the bench drove in.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned FRAME_SLOTS = 16;
  localparam int unsigned SLOT_W      = $clog2(FRAME_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

  // slot index after the current one, wrapping at the frame end
  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
    return (s == LAST_SLOT) ? '0 : s + 1'b1;
  endfunction

  // bit carried by a slot: the mapped word bit, or 0 past the used slots
  function automatic logic slot_bit(input logic [FRAME_SLOTS-1:0] word,
                                    input logic [SLOT_W-1:0]      s,
                                    input int unsigned            used);
    return (32'(s) < used) ? word[s] : 1'b0;
  endfunction
endpackage

// File: rtl/tdm_timebase.sv
module tdm_timebase
  import tdm_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_nx,
  output logic              bit_end,
  output logic              rise_evt,
  output logic              frame_end,
  output logic              bclk_o,
  output logic              sync_n_o
);
  localparam int unsigned PER  = 2 * HALF_DIV;
  localparam int unsigned PH_W = $clog2(PER);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PER - 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF_DIV - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HALF_DIV);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_nx;

  // named events shared with the data paths and the checker
  assign bit_end   = (ph_q == PH_LAST);
  assign rise_evt  = (ph_q == PH_RISE);
  assign frame_end = bit_end && (slot_q == LAST_SLOT);

  always_comb begin
    ph_nx   = bit_end ? '0 : ph_q + 1'b1;
    slot_nx = bit_end ? next_slot(slot_q) : slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= '0;
      slot_q   <= '0;
      bclk_o   <= 1'b0;
      sync_n_o <= 1'b1;
    end else begin
      ph_q     <= ph_nx;
      slot_q   <= slot_nx;
      bclk_o   <= (ph_nx >= PH_HIGH);
      sync_n_o <= (slot_nx != LAST_SLOT);
    end
  end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_pkg::*;
#(
  parameter int unsigned TX_USED = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_end,
  input  logic               frame_end,
  input  logic [SLOT_W-1:0]  slot_nx,
  input  logic [TX_USED-1:0] tx_ctl_i,
  output logic               sdo_o
);
  logic [TX_USED-1:0] shadow_q;
  logic [TX_USED-1:0] src;

  // the slot-0 bit must come from the snapshot taken at this same edge
  assign src = frame_end ? tx_ctl_i : shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      sdo_o    <= 1'b0;
    end else begin
      if (frame_end) shadow_q <= tx_ctl_i;
      if (bit_end)   sdo_o    <= slot_bit(FRAME_SLOTS'(src), slot_nx, TX_USED);
    end
  end
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_pkg::*;
#(
  parameter int unsigned RX_USED = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_evt,
  input  logic               frame_end,
  input  logic [SLOT_W-1:0]  slot_q,
  input  logic               sdi_i,
  output logic [RX_USED-1:0] rx_sts_o
);
  logic [RX_USED-1:0] cap_q;

  // one capture flop per assigned slot; other slots are never stored
  for (genvar k = 0; k < RX_USED; k++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     cap_q[k] <= 1'b0;
      else if (rise_evt && (slot_q == SLOT_W'(k)))    cap_q[k] <= sdi_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_sts_o <= '0;
    else if (frame_end) rx_sts_o <= cap_q;
  end
endmodule

// File: rtl/tdm_ctl_mux.sv
module tdm_ctl_mux
  import tdm_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned TX_USED  = 7,
  parameter int unsigned RX_USED  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TX_USED-1:0] tx_ctl_i,
  input  logic               sdi_i,
  output logic               bclk_o,
  output logic               sync_n_o,
  output logic               sdo_o,
  output logic [RX_USED-1:0] rx_sts_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_nx;
  logic              bit_end;
  logic              rise_evt;
  logic              frame_end;

  tdm_timebase #(.HALF_DIV(HALF_DIV)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_q    (slot_q),
    .slot_nx   (slot_nx),
    .bit_end   (bit_end),
    .rise_evt  (rise_evt),
    .frame_end (frame_end),
    .bclk_o    (bclk_o),
    .sync_n_o  (sync_n_o)
  );

  tdm_tx #(.TX_USED(TX_USED)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_end   (bit_end),
    .frame_end (frame_end),
    .slot_nx   (slot_nx),
    .tx_ctl_i  (tx_ctl_i),
    .sdo_o     (sdo_o)
  );

  tdm_rx #(.RX_USED(RX_USED)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_evt  (rise_evt),
    .frame_end (frame_end),
    .slot_q    (slot_q),
    .sdi_i     (sdi_i),
    .rx_sts_o  (rx_sts_o)
  );
endmodule

// File: rtl/tdm_ctl_mux_chk.sv
module tdm_ctl_mux_chk #(
  parameter int unsigned RX_USED = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bclk_o,
  input logic               sync_n_o,
  input logic               sdo_o,
  input logic               frame_end,
  input logic [RX_USED-1:0] rx_sts_o
);
  // R5
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_o != $past(sdo_o)) |-> $fell(bclk_o));

  // R2
  sync_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n_o != $past(sync_n_o)) |-> $fell(bclk_o));

  // R2
  sync_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> ($rose(sync_n_o) && $fell(bclk_o)));

  // R3
  idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_o |-> !sdo_o);

  // R7
  sts_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sts_o != $past(rx_sts_o)) |-> $past(frame_end));
endmodule

bind tdm_ctl_mux tdm_ctl_mux_chk #(.RX_USED(RX_USED)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bclk_o    (bclk_o),
  .sync_n_o  (sync_n_o),
  .sdo_o     (sdo_o),
  .frame_end (frame_end),
  .rx_sts_o  (rx_sts_o)
);

// File: tb/tb_tdm_ctl_mux.sv
module tb_tdm_ctl_mux;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int NFRAMES    = 14;

  logic       clk;
  logic       rst_n;
  logic [6:0] tx_ctl_i;
  logic       sdi_i;
  logic       bclk_o;
  logic       sync_n_o;
  logic       sdo_o;
  logic [6:0] rx_sts_o;

  tdm_ctl_mux #(.HALF_DIV(HALF), .TX_USED(7), .RX_USED(7)) dut (
    .clk(clk), .rst_n(rst_n), .tx_ctl_i(tx_ctl_i), .sdi_i(sdi_i),
    .bclk_o(bclk_o), .sync_n_o(sync_n_o), .sdo_o(sdo_o), .rx_sts_o(rx_sts_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] exp_tx_q[$];
  logic [6:0]  exp_rx_q[$];

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] far_base(input int n);
    return 16'((n * 40503 + 7467) ^ (n << 9));
  endfunction

  // R6: frame 5 repeats frame 4 in slots 0..6 and flips every unused slot
  function automatic logic [15:0] far_word(input int n);
    if (n == 5) return far_base(4) ^ 16'hFF80;
    return far_base(n);
  endfunction

  function automatic logic [6:0] txv(input int n);
    if (n == 2) return 7'h7F;
    if (n == 3) return 7'h00;
    return 7'((n * 53) ^ 42);
  endfunction

  // driver: queue the frame the far end sends, and the status it must give
  task automatic push_far(input int n);
    exp_rx_q.push_back(far_word(n)[6:0]);
  endtask

  // driver: queue the outgoing frame a control value must produce
  task automatic push_tx(input logic [6:0] v);
    exp_tx_q.push_back({9'b0, v});
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic [15:0] exp_w;
    logic [6:0]  cur_tx;
    logic [6:0]  nxt;
    logic [6:0]  sts_exp;
    logic [6:0]  hold_sts;
    realtime     t_rise;
    realtime     t_prev;
    bit          have_prev;

    rst_n    = 1'b0;
    tx_ctl_i = 7'h00;
    sdi_i    = far_word(0)[0];
    push_tx(7'h00);          // R8: first frame after reset is all zero
    push_far(0);
    cur_tx    = 7'h00;
    hold_sts  = 7'h00;
    have_prev = 0;
    t_prev    = 0;
    got       = '0;

    repeat (3) @(posedge clk);
    #1;
    check("R8", "reset bclk", int'(bclk_o), 0);
    check("R8", "reset sync_n", int'(sync_n_o), 1);
    check("R8", "reset sdo", int'(sdo_o), 0);
    check("R8", "reset status", int'(rx_sts_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int fr = 0; fr < NFRAMES; fr++) begin
      for (int s = 0; s < 16; s++) begin
        @(posedge bclk_o);
        #1;
        t_rise = $realtime;
        if (have_prev)
          check("R1", "bit period", int'(t_rise - t_prev), 2 * HALF * CLK_PERIOD);
        t_prev    = t_rise;
        have_prev = 1;
        check("R2", $sformatf("sync_n slot %0d", s), int'(sync_n_o), (s == 15) ? 0 : 1);
        check("R7", $sformatf("status hold slot %0d", s), int'(rx_sts_o), int'(hold_sts));
        got[s] = sdo_o;

        // R4: a change after the snapshot must not reach this frame
        if (s == 3) tx_ctl_i = ~cur_tx;
        if (s == 8) tx_ctl_i = txv(fr + 1);
        if (s == 15) begin
          // monitor: compare the whole outgoing frame
          exp_w = exp_tx_q.pop_front();
          check((fr % 2 == 0) ? "R3" : "R4", $sformatf("tx frame %0d", fr), int'(got), int'(exp_w));
          nxt = txv(fr + 1);
          if (fr % 2 == 1) begin
            // R4: change one system clock before the frame edge
            #(CLK_PERIOD);
            nxt = nxt ^ 7'h55;
            tx_ctl_i = nxt;
          end
          cur_tx = nxt;
          push_tx(nxt);
        end

        @(negedge bclk_o);
        #1;
        check("R1", "high half", int'($realtime - t_rise), HALF * CLK_PERIOD);
        if (s == 15) begin
          sts_exp = exp_rx_q.pop_front();
          check("R6", $sformatf("status frame %0d", fr), int'(rx_sts_o), int'(sts_exp));
          hold_sts = sts_exp;
          push_far(fr + 1);
          sdi_i = far_word(fr + 1)[0];
        end else begin
          sdi_i = far_word(fr)[s + 1];
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule